// File: doc/BRIEF.md
# Serially Controlled Audio/Video Source Selector Register

This block is a two-wire serial (I2C) slave. It owns one 8-bit routing register and answers reads with one 8-bit status byte. A fast system clock oversamples the bus clock and data lines. The block pulls the data line low through an output-enable, and the line is released when that enable is low. The routing register is decoded into selection codes and mute flags for an external video and audio crossbar.

A host writes one byte to choose the video source, the luma/chroma handling, the audio source and the audio level. The host reads the status byte to learn four input-sense flags and whether the part has been reset since the last status read. An external mute pin silences audio at any time, whatever the register holds.

Top module: `av_route_slave`

## Requirements
- R1: The slave address is the 7-bit value 1001_00x, where x equals `addr_sel`. With `addr_sel` low, the write byte is 0x90 and the read byte is 0x91. With `addr_sel` high, they are 0x92 and 0x93. Only a matching address byte is acknowledged. On a mismatch the block releases SDA and ignores the bus until the next START.
- R2: In a write, the byte after the address is stored in the routing register and acknowledged. Bytes are shifted MSB first.
- R3: A third or later byte in a write is not acknowledged and leaves the routing register unchanged.
- R4: After `rst` the register is 0x00. This gives `vid_mute`=1, `aud_mute`=1, `vid_src`=0, `aud_src`=0, `yc_mix`=0, `aud_gain`=0 and `sda_oe`=0.
- R5: Video code is register bits [5:3]. Code 001 gives `vid_src`=0 (tuner), 010 gives 1, 011 gives 2 and 100 gives 3, each with `vid_mute`=0. Codes 000 and 101..111 give `vid_mute`=1 and `vid_src`=0.
- R6: `yc_mix` is 1 only when register bit 6 is 1 and the video code is 010 or 011. Otherwise it is 0, and it is always 0 while video is muted.
- R7: Audio code is register bits [2:0], with the same code-to-`aud_src` mapping as video. Codes 000 and 101..111 give `aud_mute`=1 and `aud_src`=0.
- R8: While `mute_pin` is high, `aud_mute`=1 and `aud_src`=0 for any register value.
- R9: `aud_gain` equals register bit 7 (1 = full level, 0 = 6 dB down).
- R10: The status byte is {por flag, `s1_open`, `s1_gnd`, `s2_open`, `s2_gnd`, 3'b000}, sent MSB first. While the master acknowledges, further status bytes follow. A master not-acknowledge ends the read.
- R11: The por flag reads 1 in the first status byte after reset. It reads 0 in every status byte sent after that.
- R12: A repeated START restarts address reception. A STOP in any state returns the block to idle without changing the register.
- R13: `sda_oe` rises only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Power-on reset, active high |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Selects the low address bit |
| s1_open | input | 1 | Sense input 1 is floating |
| s1_gnd | input | 1 | Sense input 1 is grounded |
| s2_open | input | 1 | Sense input 2 is floating |
| s2_gnd | input | 1 | Sense input 2 is grounded |
| mute_pin | input | 1 | Forces audio mute when high |
| vid_src | output | 2 | Video source: 0 tuner, 1..3 inputs 1..3 |
| vid_mute | output | 1 | Video outputs muted |
| yc_mix | output | 1 | Use the separate luma/chroma path with internal mix |
| aud_src | output | 2 | Audio source: 0 tuner, 1..3 inputs 1..3 |
| aud_mute | output | 1 | Audio outputs muted |
| aud_gain | output | 1 | 1 full level, 0 attenuated |

## Verification
A wrong sequencer state shows on the bus within one SCL period. The acknowledge slot is missing or extra, or a status bit is shifted by one position, so the master's sampled values differ at the ninth clock or inside the data byte. A wrong routing register shows on the decoded outputs a few system clocks after the acknowledge falling edge, because the outputs are decoded combinationally from the register. A stuck or early-cleared por flag shows only on the first or second status read after reset, so both reads are compared.

// File: rtl/avsw_pkg.sv
package avsw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_CHK,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WCHK,
        ST_WACK,
        ST_IGNORE,
        ST_RDATA,
        ST_RREL,
        ST_RACK,
        ST_RNEXT
    } slv_state_e;

    typedef struct packed {
        logic       gain_full;
        logic       sep_yc;
        logic [2:0] vid_code;
        logic [2:0] aud_code;
    } ctrl_reg_t;

    typedef struct packed {
        logic       mute;
        logic [1:0] sel;
    } route_t;

    // Codes 1..4 select a source (sel = code-1); everything else mutes.
    function automatic route_t decode_route(input logic [2:0] code);
        route_t r;
        r.mute = 1'b1;
        r.sel  = 2'd0;
        if (code >= 3'd1 && code <= 3'd4) begin
            r.mute = 1'b0;
            r.sel  = 2'(code - 3'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
    import avsw_pkg::*;
#(
    parameter logic [BYTE_W-3:0] ADDR_HI = 6'b100100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_oe,
    output ctrl_reg_t         ctrl_q,
    output logic              status_taken
);
    localparam int            CW   = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    slv_state_e        state;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            shreg        <= '0;
            txreg        <= '0;
            sda_oe       <= 1'b0;
            ctrl_q       <= '0;
            status_taken <= 1'b0;
        end else begin
            status_taken <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: if (scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST)
                            state <= (state == ST_ADDR) ? ST_ADDR_CHK : ST_WCHK;
                    end
                    ST_ADDR_CHK: if (scl_fall) begin
                        if (shreg[BYTE_W-1:1] == {ADDR_HI, addr_sel}) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (shreg[0]) begin
                            txreg        <= status_byte;
                            sda_oe       <= ~status_byte[BYTE_W-1];
                            status_taken <= 1'b1;
                            state        <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_WCHK: if (scl_fall) begin
                        ctrl_q <= ctrl_reg_t'(shreg);
                        sda_oe <= 1'b1;
                        state  <= ST_WACK;
                    end
                    ST_WACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_IGNORE;
                    end
                    ST_IGNORE: ;
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST) state <= ST_RREL;
                        end
                        if (scl_fall) begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[BYTE_W-2];
                        end
                    end
                    ST_RREL: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                    end
                    ST_RACK: if (scl_rise) begin
                        state <= sda_lvl ? ST_IDLE : ST_RNEXT;
                    end
                    ST_RNEXT: if (scl_fall) begin
                        cnt          <= '0;
                        txreg        <= status_byte;
                        sda_oe       <= ~status_byte[BYTE_W-1];
                        status_taken <= 1'b1;
                        state        <= ST_RDATA;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R13
    sda_low_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_lvl));

    // R3
    ctrl_write_window_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q != $past(ctrl_q)) |-> ($past(state) == ST_WCHK));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/av_route_decode.sv
module av_route_decode
    import avsw_pkg::*;
(
    input  ctrl_reg_t  ctrl,
    input  logic       mute_pin,
    output logic [1:0] vid_src,
    output logic       vid_mute,
    output logic       yc_mix,
    output logic [1:0] aud_src,
    output logic       aud_mute,
    output logic       aud_gain
);
    route_t vid_r;
    route_t aud_r;

    always_comb begin
        vid_r    = decode_route(ctrl.vid_code);
        aud_r    = decode_route(ctrl.aud_code);
        vid_mute = vid_r.mute;
        vid_src  = vid_r.sel;
        yc_mix   = ctrl.sep_yc & ((ctrl.vid_code == 3'b010) | (ctrl.vid_code == 3'b011));
        aud_mute = aud_r.mute | mute_pin;
        aud_src  = aud_mute ? 2'd0 : aud_r.sel;
        aud_gain = ctrl.gain_full;
    end

endmodule

// File: rtl/av_route_slave.sv
module av_route_slave
    import avsw_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-3:0] ADDR_HI     = 6'b100100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       s1_open,
    input  logic       s1_gnd,
    input  logic       s2_open,
    input  logic       s2_gnd,
    input  logic       mute_pin,
    output logic [1:0] vid_src,
    output logic       vid_mute,
    output logic       yc_mix,
    output logic [1:0] aud_src,
    output logic       aud_mute,
    output logic       aud_gain
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic status_taken;
    logic por_flag;
    logic [BYTE_W-1:0] status_byte;
    ctrl_reg_t ctrl_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    always_ff @(posedge clk) begin
        if (rst)               por_flag <= 1'b1;
        else if (status_taken) por_flag <= 1'b0;
    end

    assign status_byte = {por_flag, s1_open, s1_gnd, s2_open, s2_gnd, 3'b000};

    i2c_slave_core #(.ADDR_HI(ADDR_HI)) u_core (
        .clk          (clk),
        .rst          (rst),
        .scl_lvl      (scl_lvl),
        .sda_lvl      (sda_lvl),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .addr_sel     (addr_sel),
        .status_byte  (status_byte),
        .sda_oe       (sda_oe),
        .ctrl_q       (ctrl_q),
        .status_taken (status_taken)
    );

    av_route_decode u_dec (
        .ctrl     (ctrl_q),
        .mute_pin (mute_pin),
        .vid_src  (vid_src),
        .vid_mute (vid_mute),
        .yc_mix   (yc_mix),
        .aud_src  (aud_src),
        .aud_mute (aud_mute),
        .aud_gain (aud_gain)
    );

    // R11
    por_no_reassert_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(por_flag));

    // R8
    mute_pin_force_chk: assert property (@(posedge clk) disable iff (rst)
        mute_pin |-> (aud_mute && aud_src == 2'd0));

    // R6
    mix_needs_video_chk: assert property (@(posedge clk) disable iff (rst)
        vid_mute |-> !yc_mix);

endmodule

// File: tb/sim_av_route_slave.sv
`timescale 1ns/1ps
module sim_av_route_slave;
    localparam int HALF = 10;
    localparam int NV   = 11;
    // {ctrl, mute_pin, vid_mute, vid_src, yc_mix, aud_mute, aud_src, aud_gain}
    localparam logic [16:0] VEC [NV] = '{
        {8'h08, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0},
        {8'h11, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0},
        {8'h5A, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 2'd1, 1'b0},
        {8'hD3, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 2'd2, 1'b1},
        {8'hE4, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd3, 1'b1},
        {8'h6D, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0},
        {8'h3E, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0},
        {8'h12, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0},
        {8'h4A, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0},
        {8'h00, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0},
        {8'h80, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic addr_sel = 1'b0, mute_pin = 1'b0;
    logic s1_open = 1'b0, s1_gnd = 1'b0, s2_open = 1'b0, s2_gnd = 1'b0;
    logic sda_oe, sda_line;
    logic [1:0] vid_src, aud_src;
    logic vid_mute, yc_mix, aud_mute, aud_gain;
    int checks = 0, fails = 0, r13_viol = 0;
    logic oe_prev = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    av_route_slave u0 (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .s1_open(s1_open), .s1_gnd(s1_gnd),
        .s2_open(s2_open), .s2_gnd(s2_gnd), .mute_pin(mute_pin),
        .vid_src(vid_src), .vid_mute(vid_mute), .yc_mix(yc_mix),
        .aud_src(aud_src), .aud_mute(aud_mute), .aud_gain(aud_gain)
    );

    // R13 monitor: the pull-down may only start while the bus clock is low
    always @(posedge clk) begin
        oe_prev <= sda_oe;
        if (!rst && sda_oe && !oe_prev && m_scl) r13_viol <= r13_viol + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hp(); m_scl = 1'b1; hp(); m_sda = 1'b0; hp(); m_scl = 1'b0; hp();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_sda = 1'b1; hp();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0; hp();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; hp(); m_scl = 1'b1;
        repeat (HALF/2) @(negedge clk);
        b = sda_line;
        repeat (HALF/2) @(negedge clk);
        m_scl = 1'b0; hp();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(master_ack);
    endtask

    task automatic write_ctrl(input logic [7:0] adr, input logic [7:0] d,
                              output logic ack_a, output logic ack_d);
        bus_start();
        send_byte(adr, ack_a);
        send_byte(d, ack_d);
        bus_stop();
        hp();
    endtask

    // {vid_mute, vid_src, yc_mix, aud_mute, aud_src, aud_gain}
    function automatic logic [7:0] outs();
        return {vid_mute, vid_src, yc_mix, aud_mute, aud_src, aud_gain};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic a1, a2, a3;
        logic [7:0] rb, rb2;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R4 reset state
        check("R4 outputs after reset", {24'd0, outs()}, {24'd0, 8'b1_00_0_1_00_0});
        check("R4 sda released after reset", {31'd0, sda_oe}, 32'd0);

        // R10 R11 first status read, two bytes
        s1_open = 1'b1; s2_gnd = 1'b1;
        bus_start();
        send_byte(8'h91, a1);
        check("R1 read address ack", {31'd0, a1}, 32'd0);
        recv_byte(1'b0, rb);
        recv_byte(1'b1, rb2);
        bus_stop(); hp();
        check("R10 R11 first status byte", {24'd0, rb}, {24'd0, 8'hC8});
        check("R10 R11 second status byte por cleared", {24'd0, rb2}, {24'd0, 8'h48});

        // R11 later read, different sense pattern
        s1_open = 1'b0; s2_gnd = 1'b0; s1_gnd = 1'b1; s2_open = 1'b1;
        bus_start();
        send_byte(8'h91, a1);
        recv_byte(1'b1, rb);
        bus_stop(); hp();
        check("R10 R11 later status byte", {24'd0, rb}, {24'd0, 8'h30});

        // R2 R5 R6 R7 R8 R9 table walk
        for (int k = 0; k < NV; k++) begin
            mute_pin = VEC[k][8];
            write_ctrl(8'h90, VEC[k][16:9], a1, a2);
            check("R2 address ack", {31'd0, a1}, 32'd0);
            check("R2 data ack", {31'd0, a2}, 32'd0);
            check("R5 R6 R7 R8 R9 decoded outputs", {24'd0, outs()}, {24'd0, VEC[k][7:0]});
        end
        mute_pin = 1'b0;

        // R3 third byte ignored
        bus_start();
        send_byte(8'h90, a1);
        send_byte(8'h11, a2);
        send_byte(8'hFF, a3);
        bus_stop(); hp();
        check("R3 third byte not acknowledged", {31'd0, a3}, 32'd1);
        check("R3 register keeps second byte", {24'd0, outs()}, {24'd0, 8'b0_01_0_0_00_0});

        // R1 address select high: old address rejected
        addr_sel = 1'b1;
        write_ctrl(8'h90, 8'hE4, a1, a2);
        check("R1 mismatched address not acknowledged", {31'd0, a1}, 32'd1);
        check("R1 mismatch leaves register", {24'd0, outs()}, {24'd0, 8'b0_01_0_0_00_0});
        write_ctrl(8'h92, 8'hE4, a1, a2);
        check("R1 matching address 0x92 ack", {31'd0, a1}, 32'd0);
        check("R1 write via 0x92 applied", {24'd0, outs()}, {24'd0, 8'b0_11_0_0_11_1});
        bus_start();
        send_byte(8'h93, a1);
        recv_byte(1'b1, rb);
        bus_stop(); hp();
        check("R1 R10 read via 0x93", {24'd0, rb}, {24'd0, 8'h30});

        // R12 repeated START after a matched address
        bus_start();
        send_byte(8'h92, a1);
        bus_start();
        send_byte(8'h92, a1);
        send_byte(8'h5A, a2);
        bus_stop(); hp();
        check("R12 repeated start restarts address", {24'd0, outs()}, {24'd0, 8'b0_10_1_0_01_0});

        // R12 repeated START after a mismatched address
        bus_start();
        send_byte(8'h90, a1);
        bus_start();
        send_byte(8'h92, a2);
        send_byte(8'h11, a3);
        bus_stop(); hp();
        check("R12 restart after mismatch ack", {31'd0, a2}, 32'd0);
        check("R12 restart after mismatch applied", {24'd0, outs()}, {24'd0, 8'b0_01_0_0_00_0});

        // R12 STOP inside a data byte
        bus_start();
        send_byte(8'h92, a1);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop(); hp();
        check("R12 partial byte then stop keeps register", {24'd0, outs()}, {24'd0, 8'b0_01_0_0_00_0});
        write_ctrl(8'h92, 8'h08, a1, a2);
        check("R12 idle after stop accepts next write", {24'd0, outs()}, {24'd0, 8'b0_00_0_1_00_0});

        check("R13 no pull-down start while SCL high", r13_viol, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule